// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

This block estimates the frequency of a fast clock of unknown rate (the test clock) by comparing it with a known reference clock. In the test clock's own domain, the test clock is first divided by four. A free-running counter then advances once per divided period. The reference domain opens a measurement window that lasts a programmable number of reference cycles. The reported count is the number of divided test periods that elapsed inside that window.

The test-domain counter is held in Gray code. It crosses into the reference domain through a two-stage synchronizer, so every sampled value is either the old count or the new one, whatever the clock ratio. The reference side converts the synchronized value to binary at the window's opening edge and at its closing edge, and reports the difference. Along with the count, it reports whether the count lies within an expected value plus or minus a tolerance.

A caller drives a one-cycle start pulse and then waits for the one-cycle done pulse, which carries the count and the range flag.

Top module: `freq_window_meter`

## Requirements
- R1: While `ref_rst_n` is low, `done_o` is 0, `count_o` is 0 and `in_range_o` is 0.
- R2: `count_o` equals the number of test-clock periods divided by 4 that elapse in a window of W reference cycles, within ±2 of the ideal value W·Tref/(4·Ttst).
- R3: A start accepted at reference edge k produces `done_o` high for exactly one cycle, set by edge k+W, where W is the effective window length.
- R4: `in_range_o` is 1 exactly when |count − expected| ≤ tolerance, and the boundary is inclusive.
- R5: A `win_len_i` of 0 selects the default window of 16000 reference cycles.
- R6: A start pulse is ignored while a window is open, including on the window's closing edge. A start in the cycle where `done_o` is high is accepted.
- R7: `exp_cnt_i` and `tol_i` are captured at the accepting edge. Later changes do not affect that measurement's `in_range_o`.
- R8: `count_o` and `in_range_o` hold their values between done pulses.
- R9: The count stays correct when the divided test clock is faster than the reference clock. A stopped test clock yields a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| tst_clk | input | 1 | Clock under test |
| tst_rst_n | input | 1 | Asynchronous active-low reset, test domain |
| start_i | input | 1 | One-cycle request to open a window |
| win_len_i | input | 16 | Window length in reference cycles (0 selects 16000) |
| exp_cnt_i | input | 18 | Expected count |
| tol_i | input | 18 | Allowed deviation from the expected count |
| done_o | output | 1 | One-cycle pulse marking a new result |
| count_o | output | 18 | Divided test-clock periods counted in the last window |
| in_range_o | output | 1 | Last count lay within expected ± tolerance |

## Verification
The window closing and a new start request can land on the same reference edge. The controller must then finish the old window and refuse the request.

The bench provokes this by holding start high across the closing edge and the following edge, which is the done cycle. It then judges the outcome by when the next done pulse arrives. Exactly W cycles after the done cycle means the closing-edge request was dropped and the done-cycle request was taken; one cycle earlier would expose an accepted closing-edge start.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fwm_state_e;

    localparam int unsigned FWM_CNT_W    = 18;
    localparam int unsigned FWM_WIN_W    = 16;
    localparam int unsigned FWM_DEF_WIN  = 16000;
    localparam int unsigned FWM_DIV_LOG2 = 2;
    localparam int unsigned FWM_SYNC_N   = 2;

endpackage

// File: rtl/fwm_tst_prescale.sv
module fwm_tst_prescale #(
    parameter int unsigned CNT_W    = fwm_pkg::FWM_CNT_W,
    parameter int unsigned DIV_LOG2 = fwm_pkg::FWM_DIV_LOG2
) (
    input  logic             tst_clk,
    input  logic             tst_rst_n,
    output logic [CNT_W-1:0] gray_o
);
    localparam int unsigned DW = (DIV_LOG2 < 1) ? 1 : DIV_LOG2;

    typedef struct packed {
        logic [DW-1:0]    div;
        logic [CNT_W-1:0] bin;
        logic [CNT_W-1:0] gray;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d     = pre_q;
        pre_d.div = pre_q.div + 1'b1;
        if (&pre_q.div) begin
            pre_d.bin  = pre_q.bin + 1'b1;
            pre_d.gray = pre_d.bin ^ (pre_d.bin >> 1);
        end
    end

    always_ff @(posedge tst_clk or negedge tst_rst_n) begin
        if (!tst_rst_n) pre_q <= '0;
        else            pre_q <= pre_d;
    end

    assign gray_o = pre_q.gray;
endmodule

// File: rtl/fwm_sync.sv
module fwm_sync #(
    parameter int unsigned W      = fwm_pkg::FWM_CNT_W,
    parameter int unsigned STAGES = fwm_pkg::FWM_SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/fwm_range_cmp.sv
module fwm_range_cmp #(
    parameter int unsigned CNT_W = fwm_pkg::FWM_CNT_W
) (
    input  logic [CNT_W-1:0] value_i,
    input  logic [CNT_W-1:0] expect_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             in_range_o
);
    logic [CNT_W-1:0] mag;

    always_comb begin
        if (value_i >= expect_i) mag = value_i - expect_i;
        else                     mag = expect_i - value_i;
        in_range_o = (mag <= tol_i);
    end
endmodule

// File: rtl/fwm_ctrl.sv
module fwm_ctrl
    import fwm_pkg::*;
#(
    parameter int unsigned CNT_W   = FWM_CNT_W,
    parameter int unsigned WIN_W   = FWM_WIN_W,
    parameter int unsigned DEF_WIN = FWM_DEF_WIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic [CNT_W-1:0] exp_cnt_i,
    input  logic [CNT_W-1:0] tol_i,
    input  logic [CNT_W-1:0] gray_sync_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic             in_range_o,
    output logic             busy_o
);
    localparam logic [WIN_W-1:0] DEF_LEN = WIN_W'(DEF_WIN);

    typedef struct packed {
        fwm_state_e       st;
        logic [WIN_W-1:0] rem;
        logic [CNT_W-1:0] snap;
        logic [CNT_W-1:0] expv;
        logic [CNT_W-1:0] tolv;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             inr;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [CNT_W-1:0] now_bin;
    logic [CNT_W-1:0] delta;
    logic             delta_ok;

    always_comb begin
        now_bin[CNT_W-1] = gray_sync_i[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            now_bin[i] = now_bin[i+1] ^ gray_sync_i[i];
        end
    end

    assign delta = now_bin - ctl_q.snap;

    fwm_range_cmp #(.CNT_W(CNT_W)) u_cmp (
        .value_i   (delta),
        .expect_i  (ctl_q.expv),
        .tol_i     (ctl_q.tolv),
        .in_range_o(delta_ok)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.rem  = (win_len_i == '0) ? DEF_LEN : win_len_i;
                    ctl_d.snap = now_bin;
                    ctl_d.expv = exp_cnt_i;
                    ctl_d.tolv = tol_i;
                end
            end
            ST_RUN: begin
                ctl_d.rem = ctl_q.rem - 1'b1;
                if (ctl_q.rem == WIN_W'(1)) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.cnt  = delta;
                    ctl_d.inr  = delta_ok;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done_o     = ctl_q.done;
    assign count_o    = ctl_q.cnt;
    assign in_range_o = ctl_q.inr;
    assign busy_o     = (ctl_q.st == ST_RUN);
endmodule

// File: rtl/freq_window_meter.sv
module freq_window_meter
    import fwm_pkg::*;
#(
    parameter int unsigned CNT_W       = FWM_CNT_W,
    parameter int unsigned WIN_W       = FWM_WIN_W,
    parameter int unsigned DEF_WIN     = FWM_DEF_WIN,
    parameter int unsigned DIV_LOG2    = FWM_DIV_LOG2,
    parameter int unsigned SYNC_STAGES = FWM_SYNC_N
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             tst_clk,
    input  logic             tst_rst_n,
    input  logic             start_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic [CNT_W-1:0] exp_cnt_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic             in_range_o
);
    logic [CNT_W-1:0] tst_gray;
    logic [CNT_W-1:0] ref_gray;
    logic             busy;

    fwm_tst_prescale #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_pre (
        .tst_clk  (tst_clk),
        .tst_rst_n(tst_rst_n),
        .gray_o   (tst_gray)
    );

    fwm_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (ref_clk),
        .rst_n  (ref_rst_n),
        .async_i(tst_gray),
        .sync_o (ref_gray)
    );

    fwm_ctrl #(.CNT_W(CNT_W), .WIN_W(WIN_W), .DEF_WIN(DEF_WIN)) u_ctrl (
        .clk        (ref_clk),
        .rst_n      (ref_rst_n),
        .start_i    (start_i),
        .win_len_i  (win_len_i),
        .exp_cnt_i  (exp_cnt_i),
        .tol_i      (tol_i),
        .gray_sync_i(ref_gray),
        .done_o     (done_o),
        .count_o    (count_o),
        .in_range_o (in_range_o),
        .busy_o     (busy)
    );
endmodule

// File: rtl/fwm_checker.sv
module fwm_checker #(
    parameter int unsigned CNT_W = fwm_pkg::FWM_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] count,
    input logic             in_range
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!done && count == '0 && !in_range));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> done);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_range) |-> done);
endmodule

bind freq_window_meter fwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (ref_clk),
    .rst_n   (ref_rst_n),
    .start   (start_i),
    .busy    (busy),
    .done    (done_o),
    .count   (count_o),
    .in_range(in_range_o)
);

// File: tb/sim_freq_window_meter.sv
`timescale 1ns/1ps
module sim_freq_window_meter;
    logic        ref_clk = 1'b0;
    logic        tst_clk = 1'b0;
    logic        ref_rst_n = 1'b0;
    logic        tst_rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] win_len_i = '0;
    logic [17:0] exp_cnt_i = '0;
    logic [17:0] tol_i = '0;
    logic        done_o;
    logic [17:0] count_o;
    logic        in_range_o;

    realtime tst_half = 1.3;
    logic    tst_en = 1'b1;
    int      errors = 0;
    int      checks = 0;

    always #4 ref_clk = ~ref_clk;
    always begin
        #(tst_half);
        if (tst_en) tst_clk = ~tst_clk;
    end

    freq_window_meter u0 (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .tst_clk(tst_clk), .tst_rst_n(tst_rst_n),
        .start_i(start_i), .win_len_i(win_len_i),
        .exp_cnt_i(exp_cnt_i), .tol_i(tol_i),
        .done_o(done_o), .count_o(count_o), .in_range_o(in_range_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one measurement; n = edges from acceptance edge to done.
    task automatic measure(input logic [15:0] w, input logic [17:0] e, input logic [17:0] t,
                           output int n, output int c, output bit r);
        @(negedge ref_clk);
        start_i = 1'b1; win_len_i = w; exp_cnt_i = e; tol_i = t;
        @(posedge ref_clk);
        @(negedge ref_clk);
        start_i = 1'b0;
        n = 0;
        do begin
            @(posedge ref_clk); #1;
            n++;
        end while (!done_o && n < 20000);
        c = int'(count_o);
        r = in_range_o;
    endtask

    function automatic bit near(input int c, input real ideal);
        real d;
        d = real'(c) - ideal;
        return (d <= 2.0) && (d >= -2.0);
    endfunction

    task automatic t_reset();
        #1;
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(count_o == '0, "R1 count", count_o, 0);
        chk(in_range_o == 1'b0, "R1 in_range", in_range_o, 0);
    endtask

    task automatic t_basic();
        int n, c; bit r;
        measure(16'd1040, 18'd800, 18'd8, n, c, r);
        chk(near(c, 800.0), "R2 count 1040", c, 800);
        chk(r == 1'b1, "R4 in range", r, 1);
        chk(n == 1040, "R3 latency 1040", n, 1040);
    endtask

    task automatic t_timing();
        int n, c; bit r;
        measure(16'd1, 18'd0, 18'd5, n, c, r);
        chk(n == 1, "R3 latency 1", n, 1);
        @(posedge ref_clk); #1;
        chk(done_o == 1'b0, "R3 single pulse", done_o, 0);
        measure(16'd37, 18'd0, 18'd0, n, c, r);
        chk(n == 37, "R3 latency 37", n, 37);
    endtask

    task automatic t_out_of_range();
        int n, c; bit r;
        measure(16'd1040, 18'd900, 18'd40, n, c, r);
        chk(r == 1'b0, "R4 above tolerance", r, 0);
        measure(16'd1040, 18'd700, 18'd40, n, c, r);
        chk(r == 1'b0, "R4 below tolerance", r, 0);
    endtask

    task automatic t_stopped();
        int n, c; bit r;
        tst_en = 1'b0;
        repeat (20) @(negedge ref_clk);
        measure(16'd100, 18'd5, 18'd5, n, c, r);
        chk(c == 0, "R9 stopped count", c, 0);
        chk(r == 1'b1, "R4 boundary inclusive", r, 1);
        measure(16'd100, 18'd5, 18'd4, n, c, r);
        chk(r == 1'b0, "R4 just outside", r, 0);
        fork
            measure(16'd60, 18'd0, 18'd0, n, c, r);
            begin
                repeat (8) @(negedge ref_clk);
                exp_cnt_i = 18'd100; tol_i = 18'd0;
            end
        join
        chk(r == 1'b1, "R7 latched expectation", r, 1);
        repeat (5) @(negedge ref_clk);
        chk(count_o == 18'd0 && in_range_o == 1'b1, "R8 hold", in_range_o, 1);
        tst_en = 1'b1;
        repeat (20) @(negedge ref_clk);
    endtask

    task automatic t_hold();
        int n, c; bit r;
        measure(16'd520, 18'd400, 18'd4, n, c, r);
        exp_cnt_i = 18'd0;
        repeat (30) @(negedge ref_clk);
        chk(int'(count_o) == c, "R8 count held", count_o, c);
        chk(in_range_o == r, "R8 flag held", in_range_o, r);
    endtask

    task automatic t_ignore();
        int n, c; bit r;
        int extra;
        fork
            measure(16'd50, 18'd0, 18'd0, n, c, r);
            begin
                repeat (10) @(negedge ref_clk);
                start_i = 1'b1; win_len_i = 16'd5;
                @(negedge ref_clk);
                start_i = 1'b0;
            end
        join
        chk(n == 50, "R6 busy start ignored", n, 50);
        extra = 0;
        repeat (60) begin
            @(posedge ref_clk); #1;
            if (done_o) extra++;
        end
        chk(extra == 0, "R6 no extra done", extra, 0);
    endtask

    task automatic t_coincide();
        int n, first, second;
        first = 0; second = 0;
        @(negedge ref_clk);
        start_i = 1'b1; win_len_i = 16'd10; exp_cnt_i = 0; tol_i = 0;
        @(posedge ref_clk);
        @(negedge ref_clk);
        start_i = 1'b0;
        for (int i = 1; i <= 30; i++) begin
            if (i == 10) start_i = 1'b1;
            if (i == 12) start_i = 1'b0;
            @(posedge ref_clk); #1;
            if (done_o && first == 0) first = i;
            else if (done_o && second == 0) second = i;
            @(negedge ref_clk);
        end
        start_i = 1'b0;
        chk(first == 10, "R6 first done", first, 10);
        chk(second == 21, "R6 done-cycle start accepted", second, 21);
    endtask

    task automatic t_default();
        int n, c; bit r;
        measure(16'd0, 18'd12308, 18'd10, n, c, r);
        chk(n == 16000, "R5 default length", n, 16000);
        chk(near(c, 16000.0 / 1.3), "R5 default count", c, 12308);
    endtask

    task automatic t_fast();
        int n, c; bit r;
        tst_half = 0.5;
        repeat (20) @(negedge ref_clk);
        measure(16'd500, 18'd1000, 18'd2, n, c, r);
        chk(near(c, 1000.0), "R9 fast clock", c, 1000);
        measure(16'd2000, 18'd4000, 18'd40, n, c, r);
        chk(near(c, 4000.0), "R2 count 2000", c, 4000);
        chk(r == 1'b1, "R4 fast in range", r, 1);
        tst_half = 1.3;
        repeat (20) @(negedge ref_clk);
    endtask

    task automatic run_all();
        t_reset();
        repeat (3) @(negedge ref_clk);
        ref_rst_n = 1'b1;
        tst_rst_n = 1'b1;
        repeat (10) @(negedge ref_clk);
        t_basic();
        t_timing();
        t_out_of_range();
        t_stopped();
        t_hold();
        t_ignore();
        t_coincide();
        t_fast();
        t_default();
    endtask

    initial begin
        fork
            run_all();
            begin
                #1ms;
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule